// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block is the register stage placed between a memory controller and one rank of DRAM devices. Chip select, the three command strobes, the address and bank buses, clock enable and termination enable are captured together on a rising clock edge and driven to the DRAM from that flop stage, so the DRAM samples each command one clock later than it would without the buffer. Every field passes through untouched, including address bit 10, whose meaning (auto-precharge or all-bank precharge) the DRAM decodes.

Alongside the forwarding path, the block checks a controller-supplied parity bit against the captured address bus and command strobes. The total number of ones over those bits and the parity bit must be even. A mismatch on a selected command, with checking enabled, makes the block pull its shared error line low for one clock. A controller that does not use parity drives the enable low, and commands still pass through normally.

An active-low reset clears every output to zero at once. Clock enable therefore stays low and holds the DRAM in power-down while the system starts. The reset is released through a two-flop synchronizer.

Top module: `cmd_regbuf`

## Requirements
- R1: Each input field (select, row strobe, column strobe, write strobe, address, bank, clock enable, termination enable) is captured on a rising edge and presented on the matching output from that edge until the next one.
- R2: While `rst_n` is low, every output is 0, including `dram_sel_n`, the three strobes, `dram_cke` and `err_pd`. Outputs clear as soon as `rst_n` falls, without waiting for a clock edge.
- R3: Address bit 10 reaches `dram_addr[10]` with the same value and latency as the other address bits.
- R4: A captured command with `sel_n`=0 and `par_en`=1 is in error when the count of ones over `addr`, `row_n`, `col_n`, `wr_n` and `par_in` is odd. When the count is even, no error is raised.
- R5: `err_pd`=1 means the error line is pulled low. It is 1 for exactly the clock cycle that follows the cycle in which the failing command is on the outputs, so one failing command gives one cycle of error.
- R6: A cycle whose captured `sel_n` is 1 (deselect) never raises `err_pd`, whatever its parity.
- R7: With `par_en`=0 captured alongside a command, no error is raised, and the command is still forwarded per R1.
- R8: After `rst_n` rises, outputs stay 0 through the first two rising edges. The third rising edge is the first one to capture inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, low selects the rank |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | AW | Address bus |
| bank | input | BW | Bank address |
| ck_en | input | 1 | Clock enable for the DRAM |
| term_en | input | 1 | Termination enable for the DRAM |
| par_in | input | 1 | Even-parity bit over address and strobes |
| par_en | input | 1 | 1 enables the parity check for this command |
| dram_sel_n | output | 1 | Registered chip select |
| dram_row_n | output | 1 | Registered row strobe |
| dram_col_n | output | 1 | Registered column strobe |
| dram_wr_n | output | 1 | Registered write strobe |
| dram_addr | output | AW | Registered address |
| dram_bank | output | BW | Registered bank address |
| dram_cke | output | 1 | Registered clock enable |
| dram_odt | output | 1 | Registered termination enable |
| err_pd | output | 1 | 1 pulls the open-drain error line low |

## Verification
The bench builds the block with AW=14 and BW=3. With these widths address bit 10 exists and can be toggled on its own, and the full eight-value bank range is covered by random stimulus. Random commands mix correct and corrupted parity, deselects and disabled checking, so a failing command can sit next to another failing command or next to a clean one. The bench also releases reset with non-zero inputs waiting, and asserts reset in the middle of a cycle while an error pulse is active.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;
  // Control bits captured together with the address and bank buses.
  typedef struct packed {
    logic sel_n;
    logic row_n;
    logic col_n;
    logic wr_n;
    logic cke;
    logic odt;
    logic par;
    logic pen;
  } ctl_t;

  localparam int CTL_W      = $bits(ctl_t);
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/cmdbuf_rst_sync.sv
`timescale 1ns/1ps
module cmdbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // The reset asserts at once and releases after STAGES rising edges.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmdbuf_stage.sv
`timescale 1ns/1ps
module cmdbuf_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/cmdbuf_parity.sv
`timescale 1ns/1ps
module cmdbuf_parity #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          row_n,
  input  logic          col_n,
  input  logic          wr_n,
  input  logic          par,
  input  logic          sel_n,
  input  logic          chk_en,
  output logic          err_pd
);
  localparam int CW = AW + 4;

  logic [CW-1:0] word;
  logic          odd;
  logic          err_next;

  always_comb begin
    word     = {addr, row_n, col_n, wr_n, par};
    odd      = ^word;
    err_next = !sel_n && chk_en && odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pd <= 1'b0;
    else        err_pd <= err_next;
  end
endmodule

// File: rtl/cmd_regbuf.sv
`timescale 1ns/1ps
module cmd_regbuf
  import cmdbuf_pkg::*;
#(
  parameter int AW = 14,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          row_n,
  input  logic          col_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank,
  input  logic          ck_en,
  input  logic          term_en,
  input  logic          par_in,
  input  logic          par_en,
  output logic          dram_sel_n,
  output logic          dram_row_n,
  output logic          dram_col_n,
  output logic          dram_wr_n,
  output logic [AW-1:0] dram_addr,
  output logic [BW-1:0] dram_bank,
  output logic          dram_cke,
  output logic          dram_odt,
  output logic          err_pd
);
  localparam int PW = AW + BW + CTL_W;

  logic          core_rst_n;
  ctl_t          ctl_in;
  ctl_t          ctl_cap;
  logic [PW-1:0] pipe_d;
  logic [PW-1:0] pipe_q;
  logic [AW-1:0] addr_cap;
  logic [BW-1:0] bank_cap;
  logic          cap_par;
  logic          cap_pen;

  cmdbuf_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );

  always_comb begin
    ctl_in.sel_n = sel_n;
    ctl_in.row_n = row_n;
    ctl_in.col_n = col_n;
    ctl_in.wr_n  = wr_n;
    ctl_in.cke   = ck_en;
    ctl_in.odt   = term_en;
    ctl_in.par   = par_in;
    ctl_in.pen   = par_en;
    pipe_d       = {addr, bank, ctl_in};
  end

  cmdbuf_stage #(.W(PW)) u_stage (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (pipe_d),
    .q     (pipe_q)
  );

  assign {addr_cap, bank_cap, ctl_cap} = pipe_q;
  assign cap_par = ctl_cap.par;
  assign cap_pen = ctl_cap.pen;

  cmdbuf_parity #(.AW(AW)) u_par (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .addr   (addr_cap),
    .row_n  (ctl_cap.row_n),
    .col_n  (ctl_cap.col_n),
    .wr_n   (ctl_cap.wr_n),
    .par    (cap_par),
    .sel_n  (ctl_cap.sel_n),
    .chk_en (cap_pen),
    .err_pd (err_pd)
  );

  assign dram_sel_n = ctl_cap.sel_n;
  assign dram_row_n = ctl_cap.row_n;
  assign dram_col_n = ctl_cap.col_n;
  assign dram_wr_n  = ctl_cap.wr_n;
  assign dram_addr  = addr_cap;
  assign dram_bank  = bank_cap;
  assign dram_cke   = ctl_cap.cke;
  assign dram_odt   = ctl_cap.odt;
endmodule

// File: rtl/cmdbuf_chk.sv
`timescale 1ns/1ps
module cmdbuf_chk #(
  parameter int AW = 14,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_rst_n,
  input logic          sel_n,
  input logic          row_n,
  input logic          col_n,
  input logic          wr_n,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] bank,
  input logic          ck_en,
  input logic          term_en,
  input logic          cap_par,
  input logic          cap_pen,
  input logic          dram_sel_n,
  input logic          dram_row_n,
  input logic          dram_col_n,
  input logic          dram_wr_n,
  input logic [AW-1:0] dram_addr,
  input logic [BW-1:0] dram_bank,
  input logic          dram_cke,
  input logic          dram_odt,
  input logic          err_pd
);
  // R1
  fwd_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> (dram_addr == $past(addr) && dram_bank == $past(bank) &&
      dram_sel_n == $past(sel_n) && dram_row_n == $past(row_n) &&
      dram_col_n == $past(col_n) && dram_wr_n == $past(wr_n) &&
      dram_cke == $past(ck_en) && dram_odt == $past(term_en)));

  generate
    if (AW > 10) begin : g_a10
      // R3
      a10_fwd_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
        $past(core_rst_n) |-> dram_addr[10] == $past(addr[10]));
    end
  endgenerate

  // R2
  rst_zero_chk: assert property (@(posedge clk)
    !core_rst_n |-> (dram_addr == '0 && dram_bank == '0 && !dram_sel_n && !dram_row_n &&
      !dram_col_n && !dram_wr_n && !dram_cke && !dram_odt && !err_pd));

  // R4
  odd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && !dram_sel_n && cap_pen &&
     (^{dram_addr, dram_row_n, dram_col_n, dram_wr_n, cap_par})) |=> err_pd);

  // R6
  no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && (dram_sel_n || !cap_pen ||
     !(^{dram_addr, dram_row_n, dram_col_n, dram_wr_n, cap_par}))) |=> !err_pd);

  // R5
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pd |-> ($past(core_rst_n) && !$past(dram_sel_n) && $past(cap_pen)));

  // R8
  rel_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !core_rst_n);
endmodule

bind cmd_regbuf cmdbuf_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .sel_n      (sel_n),
  .row_n      (row_n),
  .col_n      (col_n),
  .wr_n       (wr_n),
  .addr       (addr),
  .bank       (bank),
  .ck_en      (ck_en),
  .term_en    (term_en),
  .cap_par    (cap_par),
  .cap_pen    (cap_pen),
  .dram_sel_n (dram_sel_n),
  .dram_row_n (dram_row_n),
  .dram_col_n (dram_col_n),
  .dram_wr_n  (dram_wr_n),
  .dram_addr  (dram_addr),
  .dram_bank  (dram_bank),
  .dram_cke   (dram_cke),
  .dram_odt   (dram_odt),
  .err_pd     (err_pd)
);

// File: tb/cmd_regbuf_bench.sv
`timescale 1ns/1ps
module cmd_regbuf_bench;
  localparam int AW = 14;
  localparam int BW = 3;
  localparam int MAXCYC = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, row_n, col_n, wr_n, ck_en, term_en, par_in, par_en;
  logic [AW-1:0] addr;
  logic [BW-1:0] bank;
  logic          dram_sel_n, dram_row_n, dram_col_n, dram_wr_n, dram_cke, dram_odt, err_pd;
  logic [AW-1:0] dram_addr;
  logic [BW-1:0] dram_bank;

  int errors = 0;
  int checks = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  // kind: 0 good command, 1 bad parity, 2 deselect, 3 check disabled, 4 bit-10 probe
  typedef struct {
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    logic          s, r, c, w, k, o;
    logic          err;
    int            kind;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  cmd_regbuf #(.AW(AW), .BW(BW)) u_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n),
    .addr(addr), .bank(bank), .ck_en(ck_en), .term_en(term_en), .par_in(par_in),
    .par_en(par_en), .dram_sel_n(dram_sel_n), .dram_row_n(dram_row_n),
    .dram_col_n(dram_col_n), .dram_wr_n(dram_wr_n), .dram_addr(dram_addr),
    .dram_bank(dram_bank), .dram_cke(dram_cke), .dram_odt(dram_odt), .err_pd(err_pd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] out_word();
    return {dram_addr, dram_bank, dram_sel_n, dram_row_n, dram_col_n, dram_wr_n,
            dram_cke, dram_odt, err_pd};
  endfunction

  // Driver: sets inputs at the falling edge and queues the expected result.
  task automatic drive(input logic s, input logic r, input logic c, input logic w,
                       input logic [AW-1:0] a, input logic [BW-1:0] b,
                       input logic k, input logic o, input bit bad, input bit pen,
                       input int kind);
    item_t it;
    @(negedge clk);
    sel_n = s; row_n = r; col_n = c; wr_n = w; addr = a; bank = b;
    ck_en = k; term_en = o; par_en = pen;
    par_in = (^{a, r, c, w}) ^ bad;
    it.a = a; it.b = b; it.s = s; it.r = r; it.c = c; it.w = w; it.k = k; it.o = o;
    it.err = !s && pen && bad;
    it.kind = kind;
    exp_q.push_back(it);
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 2);
  endtask

  // Monitor: pops one item per edge and compares the outputs.
  initial begin
    item_t it;
    logic  prev_err = 1'b0;
    int    prev_kind = 2;
    string tag;
    forever begin
      @(posedge clk);
      #5;
      if (mon_on && exp_q.size() > 0) begin
        it = exp_q.pop_front();
        tag = (it.kind == 4) ? "R1 R3" : "R1";
        check(dram_addr == it.a && dram_bank == it.b && dram_sel_n == it.s &&
              dram_row_n == it.r && dram_col_n == it.c && dram_wr_n == it.w &&
              dram_cke == it.k && dram_odt == it.o, tag, "forwarded fields",
              {dram_addr, dram_bank, dram_sel_n, dram_row_n, dram_col_n, dram_wr_n, dram_cke, dram_odt},
              {it.a, it.b, it.s, it.r, it.c, it.w, it.k, it.o});
        case (prev_kind)
          1:       tag = "R4 R5";
          2:       tag = "R6";
          3:       tag = "R7";
          default: tag = "R4";
        endcase
        check(err_pd == prev_err, tag, "error pulse", {31'd0, err_pd}, {31'd0, prev_err});
        prev_err  = it.err;
        prev_kind = it.kind;
      end
    end
  end

  initial begin
    #(MAXCYC * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sel_n = 1'b1; row_n = 1'b1; col_n = 1'b1; wr_n = 1'b1;
    addr = 14'h2AAA; bank = 3'd5; ck_en = 1'b1; term_en = 1'b1; par_in = 1'b1; par_en = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    // R2 reset state
    check(out_word() == 0, "R2", "outputs in reset", out_word(), 0);

    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check(out_word() == 0, "R8", "after first edge", out_word(), 0);
    @(posedge clk); #5;
    check(out_word() == 0, "R8", "after second edge", out_word(), 0);
    @(posedge clk); #5;
    check(dram_addr == 14'h2AAA && dram_bank == 3'd5 && dram_cke && dram_odt && dram_sel_n,
          "R8", "first capture", {dram_addr, dram_bank, dram_cke, dram_odt, dram_sel_n},
          {14'h2AAA, 3'd5, 3'b111});
    mon_on = 1'b1;

    // Directed: bit 10 alone toggled, good parity.
    drive(1'b0, 1'b1, 1'b0, 1'b1, 14'h0400, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 14'h0000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4);
    drive(1'b0, 0, 1, 1, 14'h3BFF, 3'd7, 1, 1, 1'b0, 1'b1, 4);
    // Directed: isolated bad command, then back-to-back bad commands.
    drive(1'b0, 1'b0, 1'b1, 1'b1, 14'h1234, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1);
    idle();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h0F0F, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 14'h3001, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 14'h0007, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 0);
    // Directed: bad parity but deselected, and bad parity with check disabled.
    drive(1'b1, 1'b0, 1'b1, 1'b0, 14'h1111, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 2);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 14'h2222, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 3);
    idle();

    for (int i = 0; i < 400; i++) begin
      int  sel  = $urandom_range(0, 9);
      bit  s    = (sel < 2);
      bit  bad  = $urandom_range(0, 2) == 0;
      bit  pen  = $urandom_range(0, 5) != 0;
      int  kind = s ? 2 : (!pen ? 3 : (bad ? 1 : 0));
      drive(s, 1'($urandom), 1'($urandom), 1'($urandom), AW'($urandom), BW'($urandom),
            1'($urandom), 1'($urandom), bad, pen, kind);
    end
    idle();
    idle();
    wait (exp_q.size() == 0);
    @(posedge clk); #6;
    mon_on = 1'b0;

    // Mid-cycle reset while an error pulse is active.
    @(negedge clk);
    sel_n = 1'b0; row_n = 1'b0; col_n = 1'b1; wr_n = 1'b1; addr = 14'h0555; bank = 3'd7;
    ck_en = 1'b1; term_en = 1'b1; par_en = 1'b1;
    par_in = ~(^{14'h0555, 1'b0, 1'b1, 1'b1});
    @(posedge clk);
    @(posedge clk); #2;
    check(err_pd == 1'b1, "R5", "pulse before reset", {31'd0, err_pd}, 32'd1);
    #1 rst_n = 1'b0;
    #1;
    check(out_word() == 0, "R2", "async clear mid-cycle", out_word(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule